// File: doc/BRIEF.md
# Microsequenced Register-Memory Processor Core

This block is a small stored-program processor whose control unit walks every machine instruction through a fixed chain of one-cycle micro-steps. It holds an instruction pointer, an instruction register, a memory address latch, a memory data latch, four general registers, two ALU operand latches and a four-flag status register. One synchronous memory, one word wide, holds both the program and its data. Every access passes through the address latch and the data latch. Read data returns one cycle after the address is presented.

Each instruction runs in the same order. A shared fetch phase loads the instruction register and advances the instruction pointer, then the decode step selects the execute chain. When the chain ends, control goes back to fetch. The supported operations are register-plus-memory add, load, store, unconditional jump and halt. A debug port shows the index of the current micro-step, the instruction pointer and the flags, so a bench can compare sequencing against a cycle model.

States and transitions. The fetch chain is FETCH_ADDR → FETCH_RD → FETCH_CAP → FETCH_IR → IP_INC → DECODE. DECODE goes to ADD_OPA, LD_MAR, ST_MAR, JMP or HALT, according to the opcode. The add chain is ADD_OPA → ADD_MAR → ADD_RD → ADD_CAP → ADD_OPB → ADD_ALU → ADD_FLAGS → ADD_WB → FETCH_ADDR. The load chain is LD_MAR → LD_RD → LD_CAP → LD_WB → FETCH_ADDR. The store chain is ST_MAR → ST_MDR → ST_WR → FETCH_ADDR. JMP returns to FETCH_ADDR. HALT loops on itself.

Top module: `ucpu_core`

## Requirements
- R1: While reset (active low, asynchronous) is held, the block drives the following values:
    - `dbg_ip`, `dbg_step`, `dbg_flags` and `mem_addr` are 0.
    - `mem_we` and `halted` are low.
    - All registers are cleared.
- R2: The fetch phase uses micro-step indices 0 to 5 (address, memory wait, data capture, IR load, IP increment, decode). `dbg_ip` shows the incremented value from index 5 onward.
- R3: ADD adds the word at the direct address to the selected register and keeps the low 16 bits of the sum. It takes 14 cycles in total: the opcode is 3, and the execute steps take indices 6 to 13.
- R4: Only ADD writes all four flags, and they become visible at index 13. `dbg_flags` is laid out as follows:
    - bit 3: signed overflow (both operands have the same sign and the result sign differs)
    - bit 2: carry out of bit 15
    - bit 1: result is zero
    - bit 0: result bit 15
- R5: LOAD copies the addressed word into the selected register. It has opcode 1 and takes 10 cycles. It updates the zero and sign flags from the loaded word and keeps the carry and overflow flags.
- R6: STORE writes the selected register to the direct address. It has opcode 2 and takes 9 cycles. `mem_we` is high for exactly one cycle, at index 8, and the flags do not change.
- R7: JUMP loads the direct address into the instruction pointer. It has opcode 4 and takes 7 cycles. The instructions at the skipped addresses are not executed.
- R8: Opcode 0 and any opcode from 5 to 15 halt the core. From index 6 onward, `halted` stays high, and `dbg_ip` and `dbg_step` stay frozen. No further writes occur.
- R9: `dbg_step` is 0 in the first fetch cycle of each instruction, rises by one each cycle, and returns to 0 when the next fetch begins.
- R10: The instruction word is laid out as follows: opcode in bits 15:12, register select in bits 11:10, direct address in bits 9:0. The four registers are independent.
- R11: `mem_addr` always shows the memory address latch. Memory read data is captured one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Memory address (address latch) |
| mem_wdata | output | 16 | Memory write data (data latch) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High once a halt opcode has been decoded |
| dbg_step | output | 4 | Micro-step index within the current instruction |
| dbg_ip | output | 10 | Instruction pointer |
| dbg_flags | output | 4 | Status flags {overflow, carry, zero, sign} |

## Verification
A wrong sequencer state shows up on `dbg_step` within the same cycle, because the index no longer follows the cycle model. Within one instruction it also moves the `mem_we` pulse or the halt time. A latch captured in the wrong step corrupts a register or a stored word. That error is seen at the port only on the next STORE, so each program stores its results and the bench checks memory after the halt. A flag error stays visible on `dbg_flags` until the next ADD or LOAD, so the flags are checked after the halt.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

    typedef enum logic [4:0] {
        S_FETCH_ADDR, S_FETCH_RD, S_FETCH_CAP, S_FETCH_IR, S_IP_INC, S_DECODE,
        S_ADD_OPA, S_ADD_MAR, S_ADD_RD, S_ADD_CAP, S_ADD_OPB, S_ADD_ALU,
        S_ADD_FLAGS, S_ADD_WB,
        S_LD_MAR, S_LD_RD, S_LD_CAP, S_LD_WB,
        S_ST_MAR, S_ST_MDR, S_ST_WR,
        S_JMP, S_HALT
    } ustate_e;

    localparam logic [3:0] OPC_HALT  = 4'd0;
    localparam logic [3:0] OPC_LOAD  = 4'd1;
    localparam logic [3:0] OPC_STORE = 4'd2;
    localparam logic [3:0] OPC_ADD   = 4'd3;
    localparam logic [3:0] OPC_JUMP  = 4'd4;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic zero;
        logic sign;
    } flags_t;

endpackage

// File: rtl/ucpu_alu.sv
module ucpu_alu
    import ucpu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] sum,
    output flags_t            flags
);
    logic [WORD_W:0] wide;

    always_comb begin
        wide        = {1'b0, op_a} + {1'b0, op_b};
        sum         = wide[WORD_W-1:0];
        flags.carry = wide[WORD_W];
        flags.zero  = (wide[WORD_W-1:0] == '0);
        flags.sign  = wide[WORD_W-1];
        flags.ovf   = (op_a[WORD_W-1] == op_b[WORD_W-1]) &&
                      (wide[WORD_W-1] != op_a[WORD_W-1]);
    end
endmodule

// File: rtl/ucpu_regfile.sv
module ucpu_regfile #(
    parameter int WORD_W = 16,
    parameter int REG_N  = 4,
    localparam int SEL_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] regs [REG_N];

    generate
        for (genvar g = 0; g < REG_N; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = regs[rd_sel];
endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
    import ucpu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OPC_W  = 4,
    parameter int REG_N  = 4,
    parameter int STEP_W = 4,
    localparam int SEL_W  = $clog2(REG_N),
    localparam int ADDR_W = WORD_W - OPC_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halted,
    output logic [STEP_W-1:0] dbg_step,
    output logic [ADDR_W-1:0] dbg_ip,
    output logic [3:0]        dbg_flags
);
    ustate_e           state, nxt;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] ip, mar;
    logic [WORD_W-1:0] ir, mdr, opa, opb, res;
    flags_t            flags, fl_tmp, alu_flags;
    logic [WORD_W-1:0] alu_sum, rf_rdata, rf_wdata;
    logic              rf_we;

    wire [OPC_W-1:0]  ir_opc  = ir[WORD_W-1 -: OPC_W];
    wire [SEL_W-1:0]  ir_sel  = ir[ADDR_W +: SEL_W];
    wire [ADDR_W-1:0] ir_addr = ir[ADDR_W-1:0];

    ucpu_alu #(.WORD_W(WORD_W)) u_alu (
        .op_a(opa), .op_b(opb), .sum(alu_sum), .flags(alu_flags)
    );

    assign rf_we    = (state == S_ADD_WB) || (state == S_LD_WB);
    assign rf_wdata = (state == S_ADD_WB) ? res : mdr;

    ucpu_regfile #(.WORD_W(WORD_W), .REG_N(REG_N)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_sel(ir_sel),
        .wr_data(rf_wdata), .rd_sel(ir_sel), .rd_data(rf_rdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_FETCH_ADDR: nxt = S_FETCH_RD;
            S_FETCH_RD:   nxt = S_FETCH_CAP;
            S_FETCH_CAP:  nxt = S_FETCH_IR;
            S_FETCH_IR:   nxt = S_IP_INC;
            S_IP_INC:     nxt = S_DECODE;
            S_DECODE: begin
                if      (ir_opc == OPC_W'(OPC_ADD))   nxt = S_ADD_OPA;
                else if (ir_opc == OPC_W'(OPC_LOAD))  nxt = S_LD_MAR;
                else if (ir_opc == OPC_W'(OPC_STORE)) nxt = S_ST_MAR;
                else if (ir_opc == OPC_W'(OPC_JUMP))  nxt = S_JMP;
                else                                  nxt = S_HALT;
            end
            S_ADD_OPA:    nxt = S_ADD_MAR;
            S_ADD_MAR:    nxt = S_ADD_RD;
            S_ADD_RD:     nxt = S_ADD_CAP;
            S_ADD_CAP:    nxt = S_ADD_OPB;
            S_ADD_OPB:    nxt = S_ADD_ALU;
            S_ADD_ALU:    nxt = S_ADD_FLAGS;
            S_ADD_FLAGS:  nxt = S_ADD_WB;
            S_ADD_WB:     nxt = S_FETCH_ADDR;
            S_LD_MAR:     nxt = S_LD_RD;
            S_LD_RD:      nxt = S_LD_CAP;
            S_LD_CAP:     nxt = S_LD_WB;
            S_LD_WB:      nxt = S_FETCH_ADDR;
            S_ST_MAR:     nxt = S_ST_MDR;
            S_ST_MDR:     nxt = S_ST_WR;
            S_ST_WR:      nxt = S_FETCH_ADDR;
            S_JMP:        nxt = S_FETCH_ADDR;
            S_HALT:       nxt = S_HALT;
            default:      nxt = S_HALT;
        endcase
    end

    // state register and micro-step index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_FETCH_ADDR;
            step  <= '0;
        end else begin
            state <= nxt;
            if (nxt == S_FETCH_ADDR) step <= '0;
            else if (state != S_HALT) step <= step + 1'b1;
        end
    end

    // datapath registers driven by the current micro-step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip <= '0; mar <= '0; ir <= '0; mdr <= '0;
            opa <= '0; opb <= '0; res <= '0;
            flags <= '0; fl_tmp <= '0;
        end else begin
            unique case (state)
                S_FETCH_ADDR: mar <= ip;
                S_FETCH_CAP:  mdr <= mem_rdata;
                S_FETCH_IR:   ir  <= mdr;
                S_IP_INC:     ip  <= ip + 1'b1;
                S_ADD_OPA:    opa <= rf_rdata;
                S_ADD_MAR, S_LD_MAR, S_ST_MAR: mar <= ir_addr;
                S_ADD_CAP, S_LD_CAP:           mdr <= mem_rdata;
                S_ADD_OPB:    opb <= mdr;
                S_ADD_ALU: begin
                    res    <= alu_sum;
                    fl_tmp <= alu_flags;
                end
                S_ADD_FLAGS:  flags <= fl_tmp;
                S_LD_WB: begin
                    flags.zero <= (mdr == '0);
                    flags.sign <= mdr[WORD_W-1];
                end
                S_ST_MDR:     mdr <= rf_rdata;
                S_JMP:        ip  <= ir_addr;
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = (state == S_ST_WR);
    assign halted    = (state == S_HALT);
    assign dbg_step  = step;
    assign dbg_ip    = ip;
    assign dbg_flags = flags;
endmodule

// File: rtl/ucpu_checker.sv
module ucpu_checker #(
    parameter int ADDR_W = 10,
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              halted,
    input logic [STEP_W-1:0] dbg_step,
    input logic [ADDR_W-1:0] dbg_ip,
    input logic [3:0]        dbg_flags
);
    assert_step_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_step != '0 && !halted) |-> dbg_step == STEP_W'($past(dbg_step) + 1'b1));

    assert_ip_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_step == STEP_W'(5)) |-> dbg_ip == ADDR_W'($past(dbg_ip) + 1'b1));

    assert_ip_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ip != $past(dbg_ip)) |-> (dbg_step == STEP_W'(5) || dbg_step == '0));

    assert_we_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (dbg_step == STEP_W'(8) && !halted));

    assert_flags_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbg_flags) |-> (dbg_step == STEP_W'(13) || dbg_step == '0));

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(dbg_ip) && $stable(dbg_step) && !mem_we));
endmodule

bind ucpu_core ucpu_checker #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .halted(halted),
    .dbg_step(dbg_step), .dbg_ip(dbg_ip), .dbg_flags(dbg_flags)
);

// File: tb/test_ucpu_core.sv
`timescale 1ns/1ps
module test_ucpu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic        halted;
    logic [3:0]  dbg_step;
    logic [9:0]  dbg_ip;
    logic [3:0]  dbg_flags;

    int total = 0;
    int bad   = 0;

    logic [15:0] mem [0:1023];
    logic [3:0]  trace [0:63];
    int we_cnt, we_cyc, halt_cyc;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    ucpu_core i_ucpu_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted),
        .dbg_step(dbg_step), .dbg_ip(dbg_ip), .dbg_flags(dbg_flags)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int sel, input int addr);
        return {op[3:0], sel[1:0], addr[9:0]};
    endfunction

    function automatic int exp_step(input int c);
        if (c < 10) return c;
        if (c < 24) return c - 10;
        if (c < 33) return c - 24;
        return (c - 33 > 6) ? 6 : c - 33;
    endfunction

    task automatic clear_mem();
        for (int k = 0; k < 1024; k++) mem[k] = 16'h0;
    endtask

    task automatic run_prog();
        int cyc;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; we_cnt = 0; we_cyc = -1;
        while (!halted && cyc < 400) begin
            if (cyc < 64) trace[cyc] = dbg_step;
            if (mem_we) begin we_cnt++; we_cyc = cyc; end
            @(negedge clk);
            cyc++;
        end
        if (cyc < 64) trace[cyc] = dbg_step;
        halt_cyc = cyc;
    endtask

    initial begin
        logic [15:0] vals [8];
        logic [16:0] wide;
        logic [3:0]  ef;
        logic [15:0] a, b;
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                 16'hFFFF, 16'h1234, 16'hFFF3, 16'h000D};

        // R1: reset values
        repeat (2) @(negedge clk);
        check(dbg_ip == 0 && dbg_step == 0, "R1 ip/step", {dbg_ip, dbg_step}, 0);
        check(dbg_flags == 0 && !halted && !mem_we, "R1 flags/halt/we",
              {dbg_flags, halted, mem_we}, 0);
        check(mem_addr == 0, "R1 mem_addr", mem_addr, 0);

        // R3 R4 R11: sweep of add operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = vals[i]; b = vals[j];
                clear_mem();
                mem[0] = enc(1, 1, 100);
                mem[1] = enc(3, 1, 101);
                mem[2] = enc(2, 1, 102);
                mem[3] = enc(0, 0, 0);
                mem[100] = a; mem[101] = b; mem[102] = 16'hDEAD;
                run_prog();
                wide = {1'b0, a} + {1'b0, b};
                ef = {(a[15] == b[15]) && (wide[15] != a[15]), wide[16],
                      wide[15:0] == 16'h0, wide[15]};
                check(mem[102] == wide[15:0], "R3 sum", mem[102], wide[15:0]);
                check(dbg_flags == ef, "R4 flags", dbg_flags, ef);
                check(halt_cyc == 39, "R3 cycle count", halt_cyc, 39);
                if (i == 0 && j == 0) begin
                    for (int c = 0; c < 40; c++)
                        check(trace[c] == 4'(exp_step(c)), "R9 step trace",
                              trace[c], exp_step(c));
                    check(we_cnt == 1 && we_cyc == 32, "R6 write slot", we_cyc, 32);
                    check(dbg_ip == 4, "R2 ip after fetch", dbg_ip, 4);
                    repeat (4) @(negedge clk);
                    check(halted && dbg_ip == 4 && dbg_step == 6, "R8 freeze",
                          {halted, dbg_ip, dbg_step}, {1'b1, 10'd4, 4'd6});
                end
            end
        end

        // R5 R7 R8 R10: load flags, jump, register select, illegal opcode
        clear_mem();
        mem[0] = enc(1, 0, 100);
        mem[1] = enc(3, 0, 101);
        mem[2] = enc(1, 3, 103);
        mem[3] = enc(4, 0, 6);
        mem[4] = enc(2, 3, 110);
        mem[5] = enc(0, 0, 0);
        mem[6] = enc(2, 0, 104);
        mem[7] = enc(2, 3, 105);
        mem[8] = 16'hF000;
        mem[100] = 16'h7FFF; mem[101] = 16'h0001; mem[103] = 16'h0000;
        mem[104] = 16'h5555; mem[105] = 16'h5555; mem[110] = 16'hBEEF;
        run_prog();
        check(mem[104] == 16'h8000, "R10 reg0 result", mem[104], 16'h8000);
        check(mem[105] == 16'h0000, "R10 reg3 result", mem[105], 16'h0000);
        check(dbg_flags == 4'b1010, "R5 load keeps ovf/carry", dbg_flags, 4'b1010);
        check(mem[110] == 16'hBEEF, "R7 skipped store", mem[110], 16'hBEEF);
        check(halt_cyc == 65, "R7 jump timing", halt_cyc, 65);
        check(dbg_ip == 9 && halted, "R8 illegal opcode halts", dbg_ip, 9);
        check(we_cnt == 2, "R8 no extra writes", we_cnt, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule